// File: doc/BRIEF.md
# SDRAM Read Output Latency Pipeline

This block is the device-side data output path of a 16-bit synchronous DRAM model. A burst engine hands it one read word per clock together with a read-valid strobe. The block holds each word for the programmed CAS latency before it reaches the data bus. The bus is driven as a data value plus one tri-state enable per byte lane. Two byte-mask inputs turn off the matching output lane. For reads this happens after a fixed two-clock delay, so the mask works like a late output enable.

The write direction uses the same two mask inputs with no delay. A write word arriving with its valid strobe is passed straight to the storage array. Each byte lane has its own write strobe, and a lane's strobe is suppressed in the same cycle if its mask is high. The clock enable input freezes every register in the path. This models a suspended clock.

Top module: `sdq_out_path`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both bits of `dq_oe` are 0.
- R2: A word sampled with `rd_vld` high at an enabled edge appears on `dq_o` with its lanes enabled after exactly CL enabled edges. CL is taken from `cas_lat`, and the values 1, 2 and 3 give 1, 2 and 3 edges. With CL=1 the word is on the bus in the cycle right after its own edge.
- R3: When no valid read word has reached the output stage, both bits of `dq_oe` are 0, whatever the masks are.
- R4: A high `mask_lo` (lane 0, `dq_o[7:0]`) or `mask_hi` (lane 1, `dq_o[15:8]`) sampled at enabled edge k clears that lane's `dq_oe` bit for the cycle after enabled edge k+1. This two-edge delay is the same for every CL setting.
- R5: An edge with `cke` low advances no stage. Read data, read valid and read mask state all hold, so `dq_oe` and `dq_o` keep their values as long as `cas_lat` is unchanged.
- R6: A `cas_lat` value of 0 behaves as CL=1.
- R7: `arr_wr_data` equals `wr_word`. `arr_wr_be[0]` is `wr_vld & cke & ~mask_lo`, and `arr_wr_be[1]` is `wr_vld & cke & ~mask_hi`. Both take effect in the same cycle, with no register on the way.
- R8: A high mask bit during a write always blocks that lane's write strobe. The other lane is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the pipeline |
| cas_lat | input | 2 | Read latency setting (0 or 1 gives 1, then 2, 3) |
| rd_vld | input | 1 | Read word from the burst engine is valid |
| rd_word | input | 16 | Read word from the burst engine |
| wr_vld | input | 1 | Write word is valid this cycle |
| wr_word | input | 16 | Write word from the bus side |
| mask_lo | input | 1 | Byte mask for bits 7:0 |
| mask_hi | input | 1 | Byte mask for bits 15:8 |
| dq_o | output | 16 | Read data driven toward the bus |
| dq_oe | output | 2 | Per-lane tri-state enable (bit 0 low byte) |
| arr_wr_data | output | 16 | Write data to the storage array |
| arr_wr_be | output | 2 | Per-lane write strobe to the storage array |

## Verification
The bench drives a ten-word burst at each latency, including the value 0. A mask pulse is placed mid-burst on each lane separately, and a clock-enable gap is inserted mid-burst. A design that ties the mask delay to the CAS latency would blank the wrong word at CL=1 or CL=3. A design that keeps advancing while `cke` is low would shift the burst early by one word. Writes run alongside the reads with the masks changing. A write mask that was wrongly registered would block the lane one cycle late, and a missing `cke` gate would raise a strobe during the suspended cycle.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  localparam int LANES = 2;

  // Map a raw latency code to an effective stage count in 1..maxc.
  function automatic int clamp_cl(input int raw, input int maxc);
    if (raw < 1) return 1;
    if (raw > maxc) return maxc;
    return raw;
  endfunction

  // A read lane drives the bus when a word is present and its mask is clear.
  function automatic logic lane_on(input logic vld, input logic msk);
    return vld & ~msk;
  endfunction

  // A write lane strobes when the write is valid, the clock runs, and the mask is clear.
  function automatic logic wr_lane(input logic vld, input logic en, input logic msk);
    return vld & en & ~msk;
  endfunction

endpackage

// File: rtl/sdq_rd_delay.sv
module sdq_rd_delay #(
  parameter int DW     = 16,
  parameter int MAX_CL = 3,
  parameter int CLW    = $clog2(MAX_CL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           in_vld,
  input  logic [DW-1:0]  in_dat,
  input  logic [CLW-1:0] sel_cl,
  output logic           out_vld,
  output logic [DW-1:0]  out_dat
);

  logic [MAX_CL-1:0] vld_q;
  logic [DW-1:0]     dat_q [MAX_CL];

  genvar s;
  generate
    for (s = 0; s < MAX_CL; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
          end else if (adv) begin
            vld_q[0] <= in_vld;
            dat_q[0] <= in_dat;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[s] <= 1'b0;
            dat_q[s] <= '0;
          end else if (adv) begin
            vld_q[s] <= vld_q[s-1];
            dat_q[s] <= dat_q[s-1];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    out_vld = 1'b0;
    out_dat = '0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (int'(sel_cl) == i + 1) begin
        out_vld = vld_q[i];
        out_dat = dat_q[i];
      end
    end
  end

endmodule

// File: rtl/sdq_mask_delay.sv
module sdq_mask_delay #(
  parameter int LANES = 2,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LANES-1:0] msk_in,
  output logic [LANES-1:0] msk_out
);

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      logic [LAT-1:0] sh;
      if (LAT == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   sh <= '0;
          else if (adv) sh <= msk_in[l];
        end
      end else begin : g_many
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   sh <= '0;
          else if (adv) sh <= {sh[LAT-2:0], msk_in[l]};
        end
      end
      assign msk_out[l] = sh[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/sdq_wr_gate.sv
module sdq_wr_gate #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             wr_vld,
  input  logic             en,
  input  logic [DW-1:0]    wr_word,
  input  logic [LANES-1:0] msk,
  output logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] wr_be
);

  assign wr_data = wr_word;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_be
      assign wr_be[l] = sdq_pkg::wr_lane(wr_vld, en, msk[l]);
    end
  endgenerate

endmodule

// File: rtl/sdq_out_path.sv
module sdq_out_path #(
  parameter int DW       = 16,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2,
  parameter int CLW      = $clog2(MAX_CL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cke,
  input  logic [CLW-1:0] cas_lat,
  input  logic           rd_vld,
  input  logic [DW-1:0]  rd_word,
  input  logic           wr_vld,
  input  logic [DW-1:0]  wr_word,
  input  logic           mask_lo,
  input  logic           mask_hi,
  output logic [DW-1:0]  dq_o,
  output logic [1:0]     dq_oe,
  output logic [DW-1:0]  arr_wr_data,
  output logic [1:0]     arr_wr_be
);

  localparam int LANES = sdq_pkg::LANES;

  // Named internal events, visible to the bound checker.
  logic [CLW-1:0]   cl_eff;
  logic [LANES-1:0] mask_now;
  logic [LANES-1:0] rmask_dly;
  logic             rd_out_vld;
  logic [DW-1:0]    rd_out_dat;

  assign cl_eff   = CLW'(sdq_pkg::clamp_cl(int'(cas_lat), MAX_CL));
  assign mask_now = {mask_hi, mask_lo};

  sdq_rd_delay #(.DW(DW), .MAX_CL(MAX_CL), .CLW(CLW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (cke),
    .in_vld  (rd_vld),
    .in_dat  (rd_word),
    .sel_cl  (cl_eff),
    .out_vld (rd_out_vld),
    .out_dat (rd_out_dat)
  );

  sdq_mask_delay #(.LANES(LANES), .LAT(MASK_LAT)) u_msk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (cke),
    .msk_in  (mask_now),
    .msk_out (rmask_dly)
  );

  sdq_wr_gate #(.DW(DW), .LANES(LANES)) u_wr (
    .wr_vld  (wr_vld),
    .en      (cke),
    .wr_word (wr_word),
    .msk     (mask_now),
    .wr_data (arr_wr_data),
    .wr_be   (arr_wr_be)
  );

  assign dq_o = rd_out_dat;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_oe
      assign dq_oe[l] = sdq_pkg::lane_on(rd_out_vld, rmask_dly[l]);
    end
  endgenerate

endmodule

// File: rtl/sdq_out_path_chk.sv
module sdq_out_path_chk #(
  parameter int CLW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cke,
  input logic [CLW-1:0] cas_lat,
  input logic           rd_vld,
  input logic           wr_vld,
  input logic           mask_lo,
  input logic           mask_hi,
  input logic [1:0]     dq_oe,
  input logic [1:0]     arr_wr_be,
  input logic           rd_out_vld,
  input logic [1:0]     rmask_dly
);

  a_r3_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_out_vld |-> (dq_oe == 2'b00));

  a_r2_cl1_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && rd_vld && cas_lat == CLW'(1)) |=> (rd_out_vld || !$stable(cas_lat)));

  a_r6_cl0_as_cl1: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && rd_vld && cas_lat == CLW'(0)) |=> (rd_out_vld || !$stable(cas_lat)));

  a_r4_lo_mask_lat: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke, 2) && $past(cke) && $past(mask_lo, 2)) |-> !dq_oe[0]);

  a_r4_hi_mask_lat: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke, 2) && $past(cke) && $past(mask_hi, 2)) |-> !dq_oe[1]);

  a_r5_cke_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(rmask_dly) && ($stable(dq_oe) || !$stable(cas_lat))));

  a_r8_lo_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && mask_lo) |-> !arr_wr_be[0]);

  a_r8_hi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && mask_hi) |-> !arr_wr_be[1]);

  a_r7_lo_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && cke && !mask_lo) |-> arr_wr_be[0]);

  a_r7_hi_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && cke && !mask_hi) |-> arr_wr_be[1]);

  a_r7_no_cke_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (arr_wr_be == 2'b00));

endmodule

bind sdq_out_path sdq_out_path_chk #(.CLW(CLW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cas_lat    (cas_lat),
  .rd_vld     (rd_vld),
  .wr_vld     (wr_vld),
  .mask_lo    (mask_lo),
  .mask_hi    (mask_hi),
  .dq_oe      (dq_oe),
  .arr_wr_be  (arr_wr_be),
  .rd_out_vld (rd_out_vld),
  .rmask_dly  (rmask_dly)
);

// File: tb/tb_sdq_out_path.sv
module tb_sdq_out_path;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic [1:0]  cas_lat = 2'd1;
  logic        rd_vld = 1'b0;
  logic [15:0] rd_word = '0;
  logic        wr_vld = 1'b0;
  logic [15:0] wr_word = '0;
  logic        mask_lo = 1'b0;
  logic        mask_hi = 1'b0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe;
  logic [15:0] arr_wr_data;
  logic [1:0]  arr_wr_be;

  sdq_out_path dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cas_lat(cas_lat),
    .rd_vld(rd_vld), .rd_word(rd_word), .wr_vld(wr_vld), .wr_word(wr_word),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .dq_o(dq_o), .dq_oe(dq_oe),
    .arr_wr_data(arr_wr_data), .arr_wr_be(arr_wr_be)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  string tag_force = "";
  bit    cke_was_low = 1'b0;

  // Reference history: one entry per enabled edge, newest at index 0.
  typedef struct { bit v; logic [15:0] w; bit ml; bit mh; } samp_t;
  samp_t hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      cke_was_low <= 1'b0;
    end else begin
      cke_was_low <= !cke;
      if (cke) begin
        samp_t s;
        s.v = rd_vld; s.w = rd_word; s.ml = mask_lo; s.mh = mask_hi;
        hist.push_front(s);
        if (hist.size() > 8) void'(hist.pop_back());
      end
    end
  end

  task automatic fail_line(string tag, string what, int act, int exp);
    n_err++;
    $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic check_all();
    int  cl;
    bit  dv;
    logic [15:0] dw;
    bit  mk [2];
    string tag;
    cl = (cas_lat == 2'd0) ? 1 : int'(cas_lat);
    dv = 1'b0; dw = '0; mk[0] = 1'b0; mk[1] = 1'b0;
    if (hist.size() >= cl) begin dv = hist[cl-1].v; dw = hist[cl-1].w; end
    if (hist.size() >= 2) begin mk[0] = hist[1].ml; mk[1] = hist[1].mh; end
    for (int l = 0; l < 2; l++) begin
      bit eoe;
      eoe = dv && !mk[l];
      if (tag_force != "")  tag = tag_force;
      else if (cke_was_low) tag = "R5";
      else if (!dv)         tag = "R3";
      else if (mk[l])       tag = "R4";
      else                  tag = "R2";
      n_chk++;
      if (dq_oe[l] !== eoe) fail_line(tag, $sformatf("dq_oe[%0d]", l), int'(dq_oe[l]), int'(eoe));
      if (eoe) begin
        n_chk++;
        if (dq_o[l*8 +: 8] !== dw[l*8 +: 8])
          fail_line(tag, $sformatf("dq_o lane%0d", l), int'(dq_o[l*8 +: 8]), int'(dw[l*8 +: 8]));
      end
    end
    if (rst_n) begin
      bit eb [2];
      eb[0] = wr_vld && cke && !mask_lo;
      eb[1] = wr_vld && cke && !mask_hi;
      for (int l = 0; l < 2; l++) begin
        bit mm;
        mm = (l == 0) ? mask_lo : mask_hi;
        tag = (wr_vld && mm) ? "R8" : "R7";
        n_chk++;
        if (arr_wr_be[l] !== eb[l]) fail_line(tag, $sformatf("arr_wr_be[%0d]", l), int'(arr_wr_be[l]), int'(eb[l]));
      end
      n_chk++;
      if (arr_wr_data !== wr_word) fail_line("R7", "arr_wr_data", int'(arr_wr_data), int'(wr_word));
    end
  endtask

  // One cycle: check outputs of the current inputs, then apply the next set.
  task automatic cyc(bit rv, logic [15:0] rw, bit ml, bit mh, bit wv, logic [15:0] ww, bit ck);
    @(negedge clk);
    check_all();
    rd_vld = rv; rd_word = rw; mask_lo = ml; mask_hi = mh;
    wr_vld = wv; wr_word = ww; cke = ck;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int cls [4] = '{1, 2, 3, 0};
    // R1: reset state, with masks quiet and a read pending on the inputs.
    tag_force = "R1";
    rd_vld = 1'b1; rd_word = 16'hDEAD;
    cyc(1, 16'hDEAD, 0, 0, 0, 16'h0, 1);
    cyc(1, 16'hDEAD, 0, 0, 0, 16'h0, 1);
    @(negedge clk);
    check_all();
    rd_vld = 1'b0; rst_n = 1'b1;
    cyc(0, 16'h0, 0, 0, 0, 16'h0, 1);
    tag_force = "";

    foreach (cls[k]) begin
      cas_lat = 2'(cls[k]);
      tag_force = (cls[k] == 0) ? "R6" : "";
      // idle with a mask: no output must appear (R3)
      cyc(0, 16'h0, 1, 1, 0, 16'h0, 1);
      cyc(0, 16'h0, 0, 0, 0, 16'h0, 1);
      cyc(0, 16'h0, 0, 0, 0, 16'h0, 1);
      for (int i = 0; i < 10; i++) begin
        logic [15:0] w;
        bit ml, mh, wv, ck;
        w  = 16'((cls[k] + 1) * 16'h1111) ^ 16'(i * 16'h0F0F + i);
        ml = (i == 3) || (i == 4);
        mh = (i == 6);
        wv = (i % 2) == 1;
        ck = (i != 5);
        cyc(1, w, ml, mh, wv, ~w, ck);
        if (!ck) cyc(1, w, ml, mh, wv, ~w, 1'b1);
      end
      // write-only with both masks, then flush
      cyc(0, 16'h0, 1, 0, 1, 16'hA5A5, 1);
      cyc(0, 16'h0, 0, 1, 1, 16'h5A5A, 1);
      cyc(0, 16'h0, 1, 1, 1, 16'h3C3C, 1);
      for (int i = 0; i < 5; i++) cyc(0, 16'h0, 0, 0, 0, 16'h0, 1);
    end
    tag_force = "";
    @(negedge clk);
    check_all();
    finish_run();
  end

endmodule